// File: doc/BRIEF.md
# Per-pin GPIO register bank

This block is a byte-wide register file for 36 general-purpose pins. Each pin owns one control byte. Bit 0 of that byte holds the value the pin drives, bit 1 holds the value it senses, and bit 2 turns the driver on. When software turns on the driver, the sensed bit becomes a copy of the driven bit, as if the pin read back its own level. The register window is 48 bytes wide. The first eight bytes are read-only level bytes that read as zero. The next 36 bytes are the pin control bytes, and the remaining four bytes are empty.

A separate update port lets the surrounding logic report a new sensed level for one pin. Two pins are wired to interrupt outputs, and each has a fixed behaviour. Pin 1 is an active-low level source. Pin 9 follows its sensed bit, and the non-maskable request input pulses it for exactly one cycle. An update that targets a pin whose driver is on is still applied, and it raises a one-cycle error flag.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every pin byte is 0x00, except pin 1, which is 0x02 (sensed bit high). All interrupt outputs, `upd_err` and `bus_rdata` are 0.
- R2: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value otherwise. A read returns the value held before any write in the same cycle. Addresses 0 to 7 and 44 to 63 read 0x00. Addresses 8 to 43 read the byte of pin (address - 8).
- R3: Writes to addresses 0 to 7 and 44 to 63 change no pin byte.
- R4: A write to a pin byte stores bits 7:2 and bit 0 as written. If written bit 2 is 1, bit 1 takes the written bit 0. Otherwise bit 1 keeps its old value, and the written bit 1 is discarded.
- R5: An update (`pin_upd`, `pin_sel`, `pin_lvl`) replaces only bit 1 of the selected pin, one clock later. A `pin_sel` of 36 or more has no effect. When a write and an update hit the same pin in one cycle, the update's bit lands on the written value.
- R6: `irq_o[1]` is set when an update changes pin 1's bit 1 to 0, and cleared when an update changes it to 1.
- R7: `irq_o[9]` takes the new value of pin 9's bit 1 whenever an update changes that bit.
- R8: A `nmi_req` pulse sets pin 9's bit 1 to 1 on the next edge and to 0 on the edge after. This gives a one-cycle `irq_o[9]` pulse when the bit starts at 0. An external update in either of those cycles is dropped.
- R9: An update or request step that targets a pin whose bit 2 is 1 still applies, and `upd_err` is high for the following cycle only.
- R10: Bus writes never change `irq_o`. `irq_o[0]` and `irq_o[8:2]` are always 0.
- R11: An update that leaves the pin byte unchanged leaves `irq_o` unchanged, even if a bus write earlier moved the sensed bit without touching the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address in the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_upd | input | 1 | Sensed-level update strobe |
| pin_sel | input | 6 | Pin index for the update |
| pin_lvl | input | 1 | New sensed level |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_o | output | 10 | Interrupt outputs for pins 0 to 9 |
| upd_err | output | 1 | Update hit a pin whose driver is on |

## Verification
Some properties are checked on every cycle:
- the loopback rule for writes that turn on the driver;
- the zero read of the level bytes;
- that interrupts hold still in any cycle without an update;
- that `irq_o[1]` rises after a falling update;
- the shape of the request pulse;
- the error flag after an update to a driven pin.

Other behaviours need the bench's ordered scenarios:
- an update that does not change the byte after a bus write has already moved the sensed bit, and so leaves the interrupt stuck;
- a request that produces no pulse because the driver had already set the bit;
- an update dropped while a request sequence is running;
- the full read map across empty and read-only addresses.

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int NPIN    = 36,
  parameter int NLVL    = 8,
  parameter int AW      = 6,
  parameter int NIRQ    = 10,
  parameter int LVL_PIN = 1,
  parameter int NMI_PIN = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_rd,
  output logic [7:0]      bus_rdata,
  input  logic            pin_upd,
  input  logic [AW-1:0]   pin_sel,
  input  logic            pin_lvl,
  input  logic            nmi_req,
  output logic [NIRQ-1:0] irq_o,
  output logic            upd_err
);

  localparam int LAST = NLVL + NPIN;

  logic [7:0] pin_q  [NPIN];
  logic [7:0] wr_val [NPIN];
  logic       nmi_ph;
  logic       irq_lvl_q;
  logic       irq_nmi_q;

  wire [AW-1:0] rel      = bus_addr - AW'(NLVL);
  wire          in_win   = (32'(bus_addr) >= 32'(NLVL)) && (32'(bus_addr) < 32'(LAST));
  wire          wr_hit   = bus_wr && in_win;
  wire          nmi_step = nmi_ph || nmi_req;
  wire          upd_act  = nmi_step || (pin_upd && (32'(pin_sel) < 32'(NPIN)));
  wire [AW-1:0] upd_idx  = nmi_step ? AW'(NMI_PIN) : pin_sel;
  wire          upd_bit  = nmi_step ? !nmi_ph : pin_lvl;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      wr_val[i] = pin_q[i];
      if (wr_hit && rel == AW'(i))
        wr_val[i] = {bus_wdata[7:2], bus_wdata[2] ? bus_wdata[0] : pin_q[i][1], bus_wdata[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIN; i++)
        pin_q[i] <= (i == LVL_PIN) ? 8'h02 : 8'h00;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (upd_act && upd_idx == AW'(i))
          pin_q[i] <= {wr_val[i][7:2], upd_bit, wr_val[i][0]};
        else
          pin_q[i] <= wr_val[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_ph    <= 1'b0;
      irq_lvl_q <= 1'b0;
      irq_nmi_q <= 1'b0;
      upd_err   <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      nmi_ph  <= nmi_req && !nmi_ph;
      upd_err <= upd_act && wr_val[upd_idx][2];
      if (upd_act && upd_idx == AW'(LVL_PIN) && upd_bit != wr_val[LVL_PIN][1])
        irq_lvl_q <= !upd_bit;
      if (upd_act && upd_idx == AW'(NMI_PIN) && upd_bit != wr_val[NMI_PIN][1])
        irq_nmi_q <= upd_bit;
      if (bus_rd)
        bus_rdata <= in_win ? pin_q[rel] : 8'h00;
    end
  end

  always_comb begin
    irq_o          = '0;
    irq_o[LVL_PIN] = irq_lvl_q;
    irq_o[NMI_PIN] = irq_nmi_q;
  end

  // R2
  lvl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && 32'(bus_addr) < 32'(NLVL)) |=> bus_rdata == 8'h00);

  // R6
  lvl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_upd && !nmi_step && pin_sel == AW'(LVL_PIN) && !pin_lvl && pin_q[LVL_PIN][1]
     && !(wr_hit && rel == AW'(LVL_PIN))) |=> irq_o[LVL_PIN]);

  // R8
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_ph && !pin_q[NMI_PIN][1] && !(wr_hit && rel == AW'(NMI_PIN)))
    |=> irq_o[NMI_PIN] ##1 !irq_o[NMI_PIN]);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_upd && !nmi_req && !nmi_ph) |=> $stable(irq_o));

  // R9
  drv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_upd && !nmi_step && 32'(pin_sel) < 32'(NPIN) && pin_q[pin_sel][2]
     && !(wr_hit && rel == pin_sel)) |=> upd_err);

  for (genvar g = 0; g < NPIN; g++) begin : g_wchk
    // R4
    wr_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && rel == AW'(g) && bus_wdata[2] && !(upd_act && upd_idx == AW'(g)))
      |=> pin_q[g][1] == $past(bus_wdata[0]));
  end

endmodule

// File: tb/sim_gpio_pin_bank.sv
`timescale 1ns/1ps
module sim_gpio_pin_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       pin_upd = 1'b0;
  logic [5:0] pin_sel = '0;
  logic       pin_lvl = 1'b0;
  logic       nmi_req = 1'b0;
  logic [9:0] irq_o;
  logic       upd_err;

  int checks = 0;
  int errors = 0;
  logic rd_was = 1'b0;
  logic [7:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  gpio_pin_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_upd(pin_upd), .pin_sel(pin_sel), .pin_lvl(pin_lvl),
    .nmi_req(nmi_req), .irq_o(irq_o), .upd_err(upd_err)
  );

  always @(posedge clk) rd_was <= bus_rd;

  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rd_was && expq.size() > 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read data act=%02h exp=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic upd(input logic [5:0] s, input logic l);
    pin_sel = s; pin_lvl = l; pin_upd = 1'b1;
    @(negedge clk);
    pin_upd = 1'b0;
  endtask

  task automatic nmi();
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
  endtask

  task automatic finish_run();
    idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_o == 10'h000, "R1 irq", irq_o, 0);
    chk(upd_err == 1'b0, "R1 err", upd_err, 0);
    chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
    rst_n = 1'b1;
    idle();
    rd(6'd9, 8'h02, "R1");
    rd(6'd8, 8'h00, "R1");
    rd(6'd43, 8'h00, "R1");

    // R3 read-only and empty addresses ignore writes; R2 zero reads
    wr(6'd3, 8'hFF);
    wr(6'd44, 8'hFF);
    wr(6'd47, 8'hFF);
    rd(6'd3, 8'h00, "R3");
    rd(6'd44, 8'h00, "R3");
    rd(6'd47, 8'h00, "R2");
    rd(6'd63, 8'h00, "R2");
    rd(6'd8, 8'h00, "R3");
    rd(6'd43, 8'h00, "R3");

    // R4 write rules
    wr(6'd13, 8'hA5);
    rd(6'd13, 8'hA7, "R4");
    wr(6'd13, 8'h02);
    rd(6'd13, 8'h02, "R4");
    wr(6'd14, 8'h06);
    rd(6'd14, 8'h04, "R4");
    wr(6'd15, 8'h78);
    rd(6'd15, 8'h78, "R4");

    // R5 external updates
    upd(6'd20, 1'b1);
    chk(upd_err == 1'b0, "R9 no err undriven", upd_err, 0);
    rd(6'd28, 8'h02, "R5");
    upd(6'd5, 1'b0);
    rd(6'd13, 8'h00, "R5");
    upd(6'd40, 1'b1);
    chk(upd_err == 1'b0 && irq_o == 10'h000, "R5 out of range", {upd_err, irq_o}, 0);

    // R9 update to driven pin
    upd(6'd6, 1'b1);
    chk(upd_err == 1'b1, "R9 err pulse", upd_err, 1);
    idle();
    chk(upd_err == 1'b0, "R9 err one cycle", upd_err, 0);
    rd(6'd14, 8'h06, "R9");

    // R6 / R10 / R11 pin 1
    upd(6'd1, 1'b0);
    chk(irq_o == 10'h002, "R6 irq1 set", irq_o, 10'h002);
    wr(6'd9, 8'h05);
    chk(irq_o == 10'h002, "R10 write keeps irq", irq_o, 10'h002);
    rd(6'd9, 8'h07, "R4");
    upd(6'd1, 1'b1);
    chk(irq_o == 10'h002, "R11 no-change update", irq_o, 10'h002);
    chk(upd_err == 1'b1, "R9 err on pin1", upd_err, 1);
    wr(6'd9, 8'h00);
    rd(6'd9, 8'h02, "R4");
    upd(6'd1, 1'b0);
    upd(6'd1, 1'b1);
    chk(irq_o == 10'h000, "R6 irq1 clear", irq_o, 0);

    // R7 pin 9 follows
    upd(6'd9, 1'b1);
    chk(irq_o == 10'h200, "R7 irq9 high", irq_o, 10'h200);
    upd(6'd9, 1'b0);
    chk(irq_o == 10'h000, "R7 irq9 low", irq_o, 0);

    // R8 request pulse
    nmi();
    chk(irq_o == 10'h200, "R8 pulse high", irq_o, 10'h200);
    idle();
    chk(irq_o == 10'h000, "R8 pulse low", irq_o, 0);
    rd(6'd17, 8'h00, "R8");

    // R8 concurrent update dropped
    pin_sel = 6'd20; pin_lvl = 1'b0; pin_upd = 1'b1; nmi_req = 1'b1;
    @(negedge clk);
    pin_upd = 1'b0; nmi_req = 1'b0;
    chk(irq_o == 10'h200, "R8 pulse with update", irq_o, 10'h200);
    idle();
    rd(6'd28, 8'h02, "R8");

    // R10 / R11 driven pin 9 then request
    wr(6'd17, 8'h05);
    chk(irq_o == 10'h000, "R10 write pin9", irq_o, 0);
    nmi();
    chk(irq_o == 10'h000, "R11 no pulse", irq_o, 0);
    chk(upd_err == 1'b1, "R9 err request step1", upd_err, 1);
    idle();
    chk(irq_o == 10'h000, "R11 still low", irq_o, 0);
    chk(upd_err == 1'b1, "R9 err request step2", upd_err, 1);
    rd(6'd17, 8'h05, "R8");

    finish_run();
  end
endmodule